// File: doc/BRIEF.md
# DMA Interrupt Status and Enable Unit

This block gathers the completion events of sixteen DMA channels and turns them into a single level interrupt for software. The channels form two families of eight: a normal family and a dedicated family. Every channel raises two one-cycle pulses. One pulse marks the midpoint of a transfer and the other marks its completion. Each pulse is held in a 32-bit pending word until software writes a one to that bit. A 32-bit enable word with the same layout chooses which held events drive the interrupt output.

Each channel owns two adjacent bits of the word. The lower bit of the pair records the midpoint event and the upper bit records the completion event. The normal family fills the lower sixteen bits and the dedicated family fills the upper sixteen bits. Software reaches both words through a one-bit-address register port: address 0 selects the enable word and address 1 selects the pending word. Read data is combinational from the selected register. The block has no state machine. Its only sequential state is the two registers, and both return to zero on reset.

Top module: `dma_irq_ctrl`

## Requirements
- R1: A midpoint pulse on normal channel n sets pending bit 2n. A completion pulse on normal channel n sets pending bit 2n+1.
- R2: A midpoint pulse on dedicated channel n sets pending bit 16+2n. A completion pulse on dedicated channel n sets pending bit 17+2n.
- R3: A pulse sampled at a clock edge sets its pending bit at that edge, whatever the enable word holds. A pending bit never sets without a pulse.
- R4: A write to address 1 clears every pending bit whose data bit is 1 and leaves the bits written with 0 unchanged. Writing all ones clears the whole word.
- R5: When a pulse and a clearing write reach the same bit at the same edge, the bit stays set.
- R6: A write to address 0 replaces the enable word, using the pending layout. Writing 0 disables every source.
- R7: `irq` is high exactly while some bit is set in both the pending word and the enable word. It stays high until those bits are cleared or disabled.
- R8: While reset is low, the pending word and the enable word are zero and `irq` is low.
- R9: `rd_data` shows the enable word when `reg_addr` is 0 and the pending word when `reg_addr` is 1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| norm_half | input | 8 | Midpoint pulses, normal family |
| norm_end | input | 8 | Completion pulses, normal family |
| ded_half | input | 8 | Midpoint pulses, dedicated family |
| ded_end | input | 8 | Completion pulses, dedicated family |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 enable, 1 pending |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected register |
| irq | output | 1 | Combined level interrupt |

## Verification
On every cycle, the assertions check that a sampled pulse is latched and that no bit sets without one. They also check that a clearing write removes its bits unless a pulse coincides, that an enable write is taken whole, that `irq` follows the masked pending word, and that both words are zero after reset. The bit position each channel pulse lands in (R1, R2) can only be shown by the bench's scenarios. The same holds for the read mux (R9) and for sequences such as a partial clear followed by an enable change, or a reset in mid-operation.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
    localparam logic ADDR_ENABLE  = 1'b0;
    localparam logic ADDR_PENDING = 1'b1;
    localparam int   BITS_PER_CH  = 2;
endpackage

// File: rtl/dma_irq_event_map.sv
module dma_irq_event_map #(
    parameter int NCH = 8,
    localparam int RW = 2 * dma_irq_pkg::BITS_PER_CH * NCH
) (
    input  logic [NCH-1:0] norm_half,
    input  logic [NCH-1:0] norm_end,
    input  logic [NCH-1:0] ded_half,
    input  logic [NCH-1:0] ded_end,
    output logic [RW-1:0]  ev_vec
);
    localparam int HALF_W = RW / 2;

    // Pair per channel: low bit = midpoint, high bit = completion.
    for (genvar n = 0; n < NCH; n++) begin : g_ch
        assign ev_vec[2*n]            = norm_half[n];
        assign ev_vec[2*n+1]          = norm_end[n];
        assign ev_vec[HALF_W+2*n]     = ded_half[n];
        assign ev_vec[HALF_W+2*n+1]   = ded_end[n];
    end
endmodule

// File: rtl/dma_irq_pend_reg.sv
module dma_irq_pend_reg #(
    parameter int RW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] ev_vec,
    input  logic          clr_en,
    input  logic [RW-1:0] clr_mask,
    output logic [RW-1:0] pend_q
);
    logic [RW-1:0] clr_eff;

    always_comb begin
        clr_eff = clr_en ? clr_mask : '0;
    end

    // Set dominates clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_eff) | ev_vec;
        end
    end

    assert_ev_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_vec != '0) |=> ((pend_q & $past(ev_vec)) == $past(ev_vec)));

    assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend_q & ~$past(pend_q) & ~$past(ev_vec)) == '0));

    assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((pend_q & $past(clr_mask & ~ev_vec)) == '0));

    assert_collision_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((pend_q & $past(clr_mask & ev_vec)) == $past(clr_mask & ev_vec)));
endmodule

// File: rtl/dma_irq_mask_reg.sv
module dma_irq_mask_reg #(
    parameter int RW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [RW-1:0] wdata,
    output logic [RW-1:0] en_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en) begin
            en_q <= wdata;
        end
    end

    assert_enable_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (en_q == $past(wdata)));

    assert_enable_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && $past(rst_n)) |=> $stable(en_q));
endmodule

// File: rtl/dma_irq_combine.sv
module dma_irq_combine #(
    parameter int RW = 32
) (
    input  logic [RW-1:0] pend,
    input  logic [RW-1:0] en,
    output logic          irq
);
    always_comb begin
        irq = |(pend & en);
    end
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl #(
    parameter int NCH = 8,
    localparam int RW = 2 * dma_irq_pkg::BITS_PER_CH * NCH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] norm_half,
    input  logic [NCH-1:0] norm_end,
    input  logic [NCH-1:0] ded_half,
    input  logic [NCH-1:0] ded_end,
    input  logic           reg_wr,
    input  logic           reg_addr,
    input  logic [RW-1:0]  wr_data,
    output logic [RW-1:0]  rd_data,
    output logic           irq
);
    import dma_irq_pkg::*;

    logic [RW-1:0] ev_vec;
    logic [RW-1:0] pend_q;
    logic [RW-1:0] en_q;
    logic          wr_pend;
    logic          wr_enab;

    always_comb begin
        wr_pend = reg_wr && (reg_addr == ADDR_PENDING);
        wr_enab = reg_wr && (reg_addr == ADDR_ENABLE);
    end

    dma_irq_event_map #(.NCH(NCH)) u_map (
        .norm_half (norm_half),
        .norm_end  (norm_end),
        .ded_half  (ded_half),
        .ded_end   (ded_end),
        .ev_vec    (ev_vec)
    );

    dma_irq_pend_reg #(.RW(RW)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_vec   (ev_vec),
        .clr_en   (wr_pend),
        .clr_mask (wr_data),
        .pend_q   (pend_q)
    );

    dma_irq_mask_reg #(.RW(RW)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_enab),
        .wdata (wr_data),
        .en_q  (en_q)
    );

    dma_irq_combine #(.RW(RW)) u_comb (
        .pend (pend_q),
        .en   (en_q),
        .irq  (irq)
    );

    always_comb begin
        unique case (reg_addr)
            ADDR_ENABLE:  rd_data = en_q;
            ADDR_PENDING: rd_data = pend_q;
            default:      rd_data = '0;
        endcase
    end

    assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((u_pend.pend_q & u_mask.en_q) != '0));

    assert_reset_R8: assert property (@(posedge clk)
        !rst_n |=> (!rst_n || ((pend_q == '0) && (en_q == '0))));
endmodule

// File: tb/dma_irq_ctrl_tb.sv
module dma_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  norm_half = '0, norm_end = '0, ded_half = '0, ded_end = '0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dma_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .norm_half(norm_half), .norm_end(norm_end),
        .ded_half(ded_half), .ded_end(ded_end),
        .reg_wr(reg_wr), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    // {norm_half, norm_end, ded_half, ded_end, expected pending}
    localparam logic [63:0] VEC [9] = '{
        {8'h01, 8'h00, 8'h00, 8'h00, 32'h0000_0001},
        {8'h00, 8'h01, 8'h00, 8'h00, 32'h0000_0002},
        {8'h80, 8'h00, 8'h00, 8'h00, 32'h0000_4000},
        {8'h00, 8'h80, 8'h00, 8'h00, 32'h0000_8000},
        {8'h00, 8'h00, 8'h01, 8'h00, 32'h0001_0000},
        {8'h00, 8'h00, 8'h00, 8'h80, 32'h8000_0000},
        {8'hFF, 8'h00, 8'h00, 8'h00, 32'h0000_5555},
        {8'h00, 8'h00, 8'h00, 8'hFF, 32'hAAAA_0000},
        {8'h0F, 8'hF0, 8'h02, 8'h40, 32'h2004_AA55}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(input logic [7:0] nh, input logic [7:0] ne,
                         input logic [7:0] dh, input logic [7:0] de);
        norm_half = nh; norm_end = ne; ded_half = dh; ded_end = de;
        tick();
        norm_half = '0; norm_end = '0; ded_half = '0; ded_end = '0;
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; wr_data = d;
        tick();
        reg_wr = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        reg_addr = a;
        #1 d = rd_data;
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        @(negedge clk); @(negedge clk);
        // R8: reset state
        rd(1'b1, v); chk("R8 pending in reset", v, 32'h0);
        rd(1'b0, v); chk("R8 enable in reset", v, 32'h0);
        chk("R8 irq in reset", {31'h0, irq}, 32'h0);
        rst_n = 1'b1;
        tick();

        // R1/R2 table walk: pulse, read, clear all
        for (int i = 0; i < 9; i++) begin
            pulse(VEC[i][63:56], VEC[i][55:48], VEC[i][47:40], VEC[i][39:32]);
            rd(1'b1, v); chk("R1/R2 map", v, VEC[i][31:0]);
            wr(1'b1, 32'hFFFF_FFFF);
            rd(1'b1, v); chk("R4 clear all", v, 32'h0);
        end

        // R3: latch while disabled, irq stays low (R7)
        pulse(8'h04, 8'h00, 8'h00, 8'h00);   // bit 4
        rd(1'b1, v); chk("R3 latch with enable 0", v, 32'h0000_0010);
        chk("R7 irq low when disabled", {31'h0, irq}, 32'h0);

        // R6/R9: enable write and readback
        wr(1'b0, 32'h0000_0030);
        rd(1'b0, v); chk("R9 read enable", v, 32'h0000_0030);
        chk("R7 irq high", {31'h0, irq}, 32'h1);
        tick();
        chk("R7 irq holds", {31'h0, irq}, 32'h1);

        // R4: zero bits leave pending unchanged
        pulse(8'h00, 8'h04, 8'h00, 8'h00);   // bit 5
        wr(1'b1, 32'hFFFF_FFCF);
        rd(1'b1, v); chk("R4 zeros keep bits", v, 32'h0000_0030);
        wr(1'b1, 32'h0000_0010);
        rd(1'b1, v); chk("R4 partial clear", v, 32'h0000_0020);
        chk("R7 irq still high", {31'h0, irq}, 32'h1);

        // R5: event and clear on same bit, same edge
        norm_half = 8'h01; reg_wr = 1'b1; reg_addr = 1'b1; wr_data = 32'h0000_0021;
        tick();
        norm_half = '0; reg_wr = 1'b0; wr_data = '0;
        rd(1'b1, v); chk("R5 event wins", v, 32'h0000_0001);
        chk("R7 irq low after enabled bits cleared", {31'h0, irq}, 32'h0);

        // R6: writing 0 disables all
        pulse(8'h00, 8'h00, 8'hFF, 8'hFF);
        wr(1'b0, 32'hFFFF_FFFF);
        chk("R7 irq with all enabled", {31'h0, irq}, 32'h1);
        wr(1'b0, 32'h0);
        chk("R6 zero enable disables", {31'h0, irq}, 32'h0);
        rd(1'b1, v); chk("R6 pending untouched by enable write", v, 32'hFFFF_0001);

        // R8: reset mid-operation
        wr(1'b0, 32'h0000_FFFF);
        rst_n = 1'b0;
        tick();
        rd(1'b1, v); chk("R8 pending after reset", v, 32'h0);
        rd(1'b0, v); chk("R8 enable after reset", v, 32'h0);
        chk("R8 irq after reset", {31'h0, irq}, 32'h0);
        rst_n = 1'b1;
        tick();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule